// File: doc/BRIEF.md
# Converter Power and Conversion Sequencer

This block decides when a sampling converter runs and when the reference voltage that feeds it is powered. It starts conversions at one of two fixed rates, each a whole number of system clock cycles. Between conversions it can nap, with the converter off and the reference still on. It can also sleep, with both turned off. The converter is seen only through a start pulse going out and a done pulse coming back. Every completed conversion whose result can be trusted produces a one-cycle data-valid pulse.

A sleep request does not cut power at once. It is honoured only when the conversion in progress reports done. A sleeping sequencer wakes when the bus reports that its address was acknowledged. The reference then comes back on and a settling count starts. The count is also loaded by reset. One build-time option holds the first conversion back until the reference has settled, so that conversion is valid. The other option starts converting at once and suppresses data-valid for every conversion that began before settling finished.

Top module: `conv_pwr_seq`

## Requirements
- R1: During and right after reset the reference enable is high and the converter enable, start and data-valid outputs are low. Reset loads the settling count with SETTLE_CYC, as a wake does.
- R2: The converter enable is high from the cycle that carries the start pulse up to and including the cycle in which done is sampled. It is low at all other times, so in nap the converter is off between conversions.
- R3: While done comes back in time, conversion starts are SLOW_PERIOD cycles apart when speed_fast_i is 0 and FAST_PERIOD cycles apart when it is 1. If done arrives after the period has run out, the next start comes one cycle after the cycle in which done was sampled.
- R4: speed_fast_i is sampled only at a conversion start. It sets the spacing to the next start, so a change made during a conversion first affects the interval after the one already running.
- R5: sleep_req_i is sampled only on the cycle in which done is accepted. If it is high then, both enables go low on the next cycle and stay low. A sleep request made while napping still lets the next conversion run.
- R6: A pulse on addr_ack_i while asleep turns the reference enable back on in the next cycle and reloads the settling count. A pulse on addr_ack_i in any other state has no effect.
- R7: With WAIT_SETTLE = 1, the first start after a wake (or reset) comes SETTLE_CYC + 1 clock edges after the edge that sampled the wake, and the result of that conversion is valid.
- R8: With WAIT_SETTLE = 0, a conversion starts on the edge after the wake edge. Any conversion that starts while the settling count is nonzero produces no data-valid pulse, so the first one after a wake is always discarded.
- R9: data_valid_o is a one-cycle pulse in the cycle after done is accepted, and only for conversions that are not discarded.
- R10: conv_done_i is ignored outside a conversion.
- R11: conv_start_o is a one-cycle pulse that falls in the first cycle of converter enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| speed_fast_i | input | 1 | 1 selects the fast rate, 0 the slow rate |
| sleep_req_i | input | 1 | 1 requests a full power-down after the current conversion |
| addr_ack_i | input | 1 | Wake event: bus address acknowledge |
| conv_done_i | input | 1 | Converter reports that its conversion has finished |
| conv_en_o | output | 1 | Converter power enable |
| ref_en_o | output | 1 | Reference power enable |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| data_valid_o | output | 1 | One-cycle pulse marking a usable result |

## Verification
Some properties are checked on every cycle. Start is always a single pulse inside converter enable. Converter enable is never on without the reference. The reference drops only after done was accepted while sleep was requested, and comes back only after an acknowledge. Data-valid always follows an accepted done. The exact spacing of starts at each rate cannot be seen in any single cycle, and the same holds for when a speed change takes effect. Also in that group are the settling delay after a wake, which results are discarded, and the fact that acknowledges and done pulses outside their states do nothing. Only the bench's scenarios show these, by comparing both build options against a reference model and measuring the intervals.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE_NAP     = 2'd0,
        ST_CONVERTING   = 2'd1,
        ST_SLEEP        = 2'd2,
        ST_REF_SETTLING = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       discard;
        logic       start;
        logic       valid;
    } seq_regs_t;

endpackage

// File: rtl/seq_pace_timer.sv
module seq_pace_timer #(
    parameter int SLOW_PERIOD = 480_769,
    parameter int FAST_PERIOD = 120_048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic fast_i,
    output logic expired_o
);
    localparam int MAX_PERIOD = (SLOW_PERIOD > FAST_PERIOD) ? SLOW_PERIOD : FAST_PERIOD;
    localparam int CNT_W      = $clog2(MAX_PERIOD + 1);
    localparam logic [CNT_W-1:0] SLOW_LOAD = CNT_W'(SLOW_PERIOD - 1);
    localparam logic [CNT_W-1:0] FAST_LOAD = CNT_W'(FAST_PERIOD - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = fast_i ? FAST_LOAD : SLOW_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/seq_settle_timer.sv
module seq_settle_timer #(
    parameter int SETTLE_CYC = 1_200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic settled_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SETTLE_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = FULL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= FULL;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign settled_o = (cnt_q == '0);

endmodule

// File: rtl/conv_pwr_seq.sv
module conv_pwr_seq
    import conv_seq_pkg::*;
#(
    parameter int SLOW_PERIOD = 480_769,
    parameter int FAST_PERIOD = 120_048,
    parameter int SETTLE_CYC  = 1_200_000,
    parameter bit WAIT_SETTLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_fast_i,
    input  logic sleep_req_i,
    input  logic addr_ack_i,
    input  logic conv_done_i,
    output logic conv_en_o,
    output logic ref_en_o,
    output logic conv_start_o,
    output logic data_valid_o
);
    seq_regs_t r_d, r_q;

    logic pace_expired;
    logic settled;
    logic pace_load;
    logic settle_restart;
    logic settle_gate;
    logic begin_conv;

    seq_pace_timer #(
        .SLOW_PERIOD (SLOW_PERIOD),
        .FAST_PERIOD (FAST_PERIOD)
    ) u_pace (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (pace_load),
        .fast_i    (speed_fast_i),
        .expired_o (pace_expired)
    );

    seq_settle_timer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (settle_restart),
        .settled_o (settled)
    );

    // Variant choice: hold the first conversion for a settled reference,
    // or start at once and let the discard flag mark the result.
    generate
        if (WAIT_SETTLE) begin : g_hold
            assign settle_gate = settled;
        end else begin : g_discard
            assign settle_gate = 1'b1;
        end
    endgenerate

    always_comb begin
        r_d            = r_q;
        r_d.start      = 1'b0;
        r_d.valid      = 1'b0;
        begin_conv     = 1'b0;
        settle_restart = 1'b0;

        unique case (r_q.state)
            ST_IDLE_NAP: begin
                begin_conv = pace_expired;
            end
            ST_CONVERTING: begin
                if (conv_done_i) begin
                    r_d.valid = ~r_q.discard;
                    r_d.state = sleep_req_i ? ST_SLEEP : ST_IDLE_NAP;
                end
            end
            ST_SLEEP: begin
                if (addr_ack_i) begin
                    r_d.state      = ST_REF_SETTLING;
                    settle_restart = 1'b1;
                end
            end
            ST_REF_SETTLING: begin
                begin_conv = settle_gate;
            end
            default: begin
                r_d.state = ST_REF_SETTLING;
            end
        endcase

        if (begin_conv) begin
            r_d.state   = ST_CONVERTING;
            r_d.start   = 1'b1;
            r_d.discard = ~settled;
        end
        pace_load = begin_conv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_REF_SETTLING;
            r_q.discard <= 1'b0;
            r_q.start   <= 1'b0;
            r_q.valid   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_en_o    = (r_q.state == ST_CONVERTING);
    assign ref_en_o     = (r_q.state != ST_SLEEP);
    assign conv_start_o = r_q.start;
    assign data_valid_o = r_q.valid;

endmodule

// File: rtl/conv_pwr_seq_chk.sv
module conv_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_req_i,
    input logic addr_ack_i,
    input logic conv_done_i,
    input logic conv_en_o,
    input logic ref_en_o,
    input logic conv_start_o,
    input logic data_valid_o
);
    AST_START_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n) conv_start_o |-> conv_en_o); // R11
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) conv_start_o |=> !conv_start_o); // R11
    AST_CONV_ROSE_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(conv_en_o) |-> conv_start_o); // R11
    AST_CONV_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(conv_en_o) |-> $past(conv_done_i)); // R2
    AST_CONV_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n) conv_en_o |-> ref_en_o); // R5
    AST_SLEEP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(ref_en_o) |-> $past(conv_en_o && conv_done_i && sleep_req_i)); // R5
    AST_WAKE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n) $rose(ref_en_o) |-> $past(addr_ack_i)); // R6
    AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) data_valid_o |-> $past(conv_en_o && conv_done_i)); // R9
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) data_valid_o |=> !data_valid_o); // R9
endmodule

bind conv_pwr_seq conv_pwr_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req_i  (sleep_req_i),
    .addr_ack_i   (addr_ack_i),
    .conv_done_i  (conv_done_i),
    .conv_en_o    (conv_en_o),
    .ref_en_o     (ref_en_o),
    .conv_start_o (conv_start_o),
    .data_valid_o (data_valid_o)
);

// File: tb/test_conv_pwr_seq.sv
module test_conv_pwr_seq;
    localparam int SLOW = 40;
    localparam int FAST = 12;
    localparam int SET  = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic speed_fast = 1'b0, sleep_req = 1'b0, addr_ack = 1'b0;
    logic [1:0] done_m = '0, extra_done = '0;
    logic [1:0] conv_done;
    logic [1:0] conv_en, ref_en, conv_start, data_valid;
    assign conv_done = done_m | extra_done;

    conv_pwr_seq #(.SLOW_PERIOD(SLOW), .FAST_PERIOD(FAST), .SETTLE_CYC(SET), .WAIT_SETTLE(1'b1)) i_conv_pwr_seq (
        .clk(clk), .rst_n(rst_n), .speed_fast_i(speed_fast), .sleep_req_i(sleep_req),
        .addr_ack_i(addr_ack), .conv_done_i(conv_done[0]), .conv_en_o(conv_en[0]),
        .ref_en_o(ref_en[0]), .conv_start_o(conv_start[0]), .data_valid_o(data_valid[0]));

    conv_pwr_seq #(.SLOW_PERIOD(SLOW), .FAST_PERIOD(FAST), .SETTLE_CYC(SET), .WAIT_SETTLE(1'b0)) i_conv_pwr_seq_discard (
        .clk(clk), .rst_n(rst_n), .speed_fast_i(speed_fast), .sleep_req_i(sleep_req),
        .addr_ack_i(addr_ack), .conv_done_i(conv_done[1]), .conv_en_o(conv_en[1]),
        .ref_en_o(ref_en[1]), .conv_start_o(conv_start[1]), .data_valid_o(data_valid[1]));

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // Behavioural reference: 0 nap, 1 converting, 2 asleep, 3 settling
    int m_st[2], m_pace[2], m_set[2];
    bit m_disc[2], m_start[2], m_dv[2];
    int t_nst, t_op, t_os;
    bit t_go;

    always @(posedge clk) begin
        cyc++;
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_st[k] = 3; m_pace[k] = 0; m_set[k] = SET;
                m_disc[k] = 0; m_start[k] = 0; m_dv[k] = 0;
            end else begin
                t_nst = m_st[k]; t_op = m_pace[k]; t_os = m_set[k]; t_go = 0;
                m_start[k] = 0; m_dv[k] = 0;
                m_pace[k] = (t_op > 0) ? t_op - 1 : 0;
                m_set[k]  = (t_os > 0) ? t_os - 1 : 0;
                case (m_st[k])
                    0: t_go = (t_op == 0);
                    1: if (conv_done[k]) begin
                           m_dv[k] = !m_disc[k];
                           t_nst = sleep_req ? 2 : 0;
                       end
                    2: if (addr_ack) begin
                           t_nst = 3;
                           m_set[k] = SET;
                       end
                    default: t_go = (k == 0) ? (t_os == 0) : 1'b1;
                endcase
                if (t_go) begin
                    t_nst = 1; m_start[k] = 1;
                    m_pace[k] = (speed_fast ? FAST : SLOW) - 1;
                    m_disc[k] = (t_os != 0);
                end
                m_st[k] = t_nst;
            end
        end
    end

    int lat = 4;
    int dcnt[2] = '{0, 0};
    int last_start[2] = '{0, 0};
    int prev_start[2] = '{0, 0};
    bit fw[2] = '{0, 0};
    bit en_prev[2] = '{0, 0};
    bit done_prev[2] = '{0, 0};

    always @(negedge clk) begin
        if (!finished) begin
            for (int k = 0; k < 2; k++) begin
                check(conv_en[k] == (m_st[k] == 1), "R2 conv_en", conv_en[k], m_st[k] == 1);
                check(ref_en[k] == (m_st[k] != 2), "R5 ref_en", ref_en[k], m_st[k] != 2);
                check(conv_start[k] == m_start[k], "R11 conv_start", conv_start[k], m_start[k]);
                check(data_valid[k] == m_dv[k], "R9 data_valid", data_valid[k], m_dv[k]);
                if (en_prev[k] && done_prev[k] && fw[k]) begin
                    check(data_valid[k] == (k == 0), (k == 0) ? "R7 first result valid" : "R8 first result discarded",
                          data_valid[k], k == 0);
                    fw[k] = 0;
                end
                if (conv_start[k]) begin
                    prev_start[k] = last_start[k];
                    last_start[k] = cyc;
                    dcnt[k] = lat;
                end else if (dcnt[k] > 0) begin
                    dcnt[k]--;
                end
                done_m[k] = (dcnt[k] == 1);
                en_prev[k] = conv_en[k];
                done_prev[k] = done_m[k];
            end
        end
    end

    task automatic wait_start(input int k);
        @(negedge clk);
        while (!conv_start[k]) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    int rel, m, t0;
    initial begin
        repeat (3) @(negedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            check(ref_en[k] == 1'b1, "R1 reset ref_en", ref_en[k], 1);
            check(conv_en[k] == 1'b0, "R1 reset conv_en", conv_en[k], 0);
            check(conv_start[k] == 1'b0 && data_valid[k] == 1'b0, "R1 reset pulses", conv_start[k] | data_valid[k], 0);
        end
        @(negedge clk);
        rst_n = 1'b1; rel = cyc; fw[0] = 1; fw[1] = 1;
        wait_start(1);
        check(last_start[1] - rel == 1, "R8 immediate start", last_start[1] - rel, 1);
        wait_start(0);
        check(last_start[0] - rel == SET + 1, "R7 settle hold", last_start[0] - rel, SET + 1);

        wait_start(0);
        check(last_start[0] - prev_start[0] == SLOW, "R3 slow interval", last_start[0] - prev_start[0], SLOW);

        // R4: change speed during a conversion
        wait_start(0);
        speed_fast = 1'b1;
        wait_start(0);
        check(last_start[0] - prev_start[0] == SLOW, "R4 change deferred", last_start[0] - prev_start[0], SLOW);
        wait_start(0);
        check(last_start[0] - prev_start[0] == FAST, "R3 fast interval", last_start[0] - prev_start[0], FAST);

        // long conversion beyond the period
        lat = 20;
        wait_start(0);
        wait_start(0);
        check(last_start[0] - prev_start[0] == 21, "R3 late done restart", last_start[0] - prev_start[0], 21);
        lat = 4;
        wait_start(0);

        // R6 / R10: stray acknowledge and done while napping
        wait_start(0);
        repeat (6) @(negedge clk);
        extra_done = 2'b01; addr_ack = 1'b1;
        @(negedge clk);
        extra_done = 2'b00; addr_ack = 1'b0;
        #1;
        check(conv_en[0] == 1'b0, "R10 stray done ignored", conv_en[0], 0);
        wait_start(0);
        check(last_start[0] - prev_start[0] == FAST, "R6 ack in nap no effect", last_start[0] - prev_start[0], FAST);

        // R5: sleep deferred to end of conversion
        wait_start(0);
        t0 = last_start[0];
        sleep_req = 1'b1;
        while (ref_en[0]) @(negedge clk);
        check(cyc - t0 == 4, "R5 sleep after done", cyc - t0, 4);
        while (ref_en[1]) @(negedge clk);
        repeat (40) @(negedge clk);
        sleep_req = 1'b0;
        repeat (20) @(negedge clk);
        #1;
        check(ref_en == 2'b00 && conv_en == 2'b00, "R5 stays asleep", {ref_en, conv_en}, 0);

        addr_ack = 1'b1; m = cyc; fw[0] = 1; fw[1] = 1;
        @(negedge clk);
        addr_ack = 1'b0;
        #1;
        check(ref_en == 2'b11, "R6 wake restores ref", ref_en, 3);
        repeat (9) @(negedge clk);
        addr_ack = 1'b1;
        @(negedge clk);
        addr_ack = 1'b0;
        wait_start(0);
        check(last_start[0] - m == SET + 2, "R7 wake settle", last_start[0] - m, SET + 2);
        repeat (100) @(negedge clk);
        finish_run();
    end
endmodule